// File: doc/BRIEF.md
# Serial Enhancement Control Register

This block holds one byte of auxiliary control bits for a frequency-synthesizer divider. It shares a serial clock and data pair with the main divider interface. While the enhancement strobe is high and the main serial strobe is low, bits shift into a staging register on each rising serial clock. The falling edge of the enhancement strobe copies the staged byte into an active buffer. A byte is copied only when exactly eight serial clocks arrived in that strobe window; otherwise the old byte is kept and a one-cycle error pulse is raised. Control outputs therefore never show a half-shifted byte.

In parallel mode the byte comes from an 8-bit data bus on the rising edge of the enhancement strobe. In direct mode the strobe does nothing. All asynchronous inputs are synchronized to the system clock, and every edge is detected from the synchronized copies. Five bits of the active buffer drive named control outputs. The three reserved bits are stored but go nowhere. An active-low enable forces all five outputs to 0 while it is high.

Top module: `enh_ctrl_reg`

## Requirements
- R1: In serial mode (`mode_direct`=0, `mode_serial`=1), the first serial bit of a window lands in byte bit 7 and the eighth lands in byte bit 0.
- R2: A serially staged byte reaches the outputs only after the falling edge of `enh_wr`. The outputs keep their previous value throughout the shifting window.
- R3: A window that ends with a count of serial clock rising edges other than 8 leaves the active byte unchanged. Such a window raises `frame_err` for exactly one clock cycle.
- R4: A serial clock edge is neither shifted nor counted while `ser_wr` is high.
- R5: In parallel mode (`mode_direct`=0, `mode_serial`=0), `par_data` is loaded on the rising edge of `enh_wr`. The falling edge has no effect in this mode.
- R6: In direct mode (`mode_direct`=1), no `enh_wr` activity or serial traffic changes the active byte, and `frame_err` stays low.
- R7: While `enh_en_n` is high, all five control outputs are 0.
- R8: While `enh_en_n` is low, the outputs map to active byte bits as follows: `pwr_down`=bit 4, `cnt_load`=bit 3, `msel_route`=bit 2, `pre_route`=bit 1, `ref_oe`=bit 0.
- R9: Byte bits 7 to 5 are stored, but no value of them affects any output.
- R10: A synchronous active-low reset clears the active byte, so all control outputs read 0.
- R11: A load takes effect at the third rising `clk` edge after the `enh_wr` edge is first sampled (two synchronizer stages plus the buffer register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_direct | input | 1 | 1 selects direct mode (no loading) |
| mode_serial | input | 1 | With mode_direct=0: 1 selects serial mode, 0 selects parallel mode |
| ser_clk | input | 1 | Shared serial clock, asynchronous |
| ser_data | input | 1 | Shared serial data, asynchronous |
| ser_wr | input | 1 | Main-register serial strobe; high blocks shifting |
| enh_wr | input | 1 | Enhancement strobe: serial window / parallel load edge |
| par_data | input | 8 | Parallel byte, bit 7 is the first serial position |
| enh_en_n | input | 1 | Active-low enable for the control outputs |
| pwr_down | output | 1 | Power-down control |
| cnt_load | output | 1 | Counter-load control |
| msel_route | output | 1 | Routes the modulus-select signal to the test output |
| pre_route | output | 1 | Routes the prescaler signal to the test output |
| ref_oe | output | 1 | Reference/comparison output enable |
| frame_err | output | 1 | One-cycle pulse on a serial window with a bad bit count |

## Verification
Each `enh_wr` edge reaches the active byte at the third rising clock edge after the input changes. The serial clock is held at each level for several cycles, so every serial edge passes the synchronizer cleanly. The bench waits six clock cycles after every strobe edge, then checks at the falling clock edge, well after the result is due. The enable gating is combinational, so those checks follow a one-cycle settle. Error pulses are counted by a monitor at each falling edge and compared with the expected count after every window.

// File: rtl/ecr_pkg.sv
// Package: shared widths, byte bit positions and the control bundle
// for the enhancement control register.
package ecr_pkg;
    localparam int unsigned ECR_W = 8;

    // Bit positions in the active byte; bit 7 is the first serial bit.
    localparam int unsigned POS_PWR  = 4;
    localparam int unsigned POS_CNT  = 3;
    localparam int unsigned POS_MSEL = 2;
    localparam int unsigned POS_PRE  = 1;
    localparam int unsigned POS_OE   = 0;
    localparam int unsigned CTL_N    = 5;

    typedef struct packed {
        logic pwr_down;
        logic cnt_load;
        logic msel_route;
        logic pre_route;
        logic ref_oe;
    } ecr_ctl_t;
endpackage

// File: rtl/ecr_sync.sv
// Module: ecr_sync
// A multi-bit synchronizer: each bit passes through STAGES flops.
// Assumes every bit is either a slow level or a strobe that stays stable
// for several clk cycles, so the bits need no coherence with each other.
module ecr_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            // One synchronizer stage, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[i] <= '0;
                else if (i == 0) pipe[i] <= d;
                else pipe[i] <= pipe[(i == 0) ? 0 : i - 1];
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/ecr_shift.sv
// Module: ecr_shift
// The serial staging register and the window bit counter. The counter
// clears on the rising strobe edge and saturates above W. On the falling
// strobe edge it raises cap (count == W) or bad (any other count).
// Assumes all inputs are already synchronized to clk.
module ecr_shift #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_en,
    input  logic         sclk_rise,
    input  logic         sdata,
    input  logic         ewr_s,
    input  logic         ewr_rise,
    input  logic         ewr_fall,
    input  logic         swr_s,
    output logic [W-1:0] stage,
    output logic         cap,
    output logic         bad
);
    localparam int unsigned CW = $clog2(W + 2);

    logic [CW-1:0] cnt_q;
    logic          shift_en;

    assign shift_en = ser_en && ewr_s && !swr_s && sclk_rise;

    // Staging register: the first bit ends up in the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) stage <= '0;
        else if (shift_en) stage <= {stage[W-2:0], sdata};
    end

    // Window bit counter, saturating at W+1.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (ewr_rise) cnt_q <= shift_en ? CW'(1) : '0;
        else if (shift_en && cnt_q != CW'(W + 1)) cnt_q <= cnt_q + CW'(1);
    end

    assign cap = ser_en && ewr_fall && (cnt_q == CW'(W));
    assign bad = ser_en && ewr_fall && (cnt_q != CW'(W));

    // R4
    // hold_on_swr_chk
    hold_on_swr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swr_s |=> $stable(stage));
endmodule

// File: rtl/ecr_decode.sv
// Module: ecr_decode
// Maps the active byte onto the control bundle and gates it with the
// active-low enable. Only bits 4..0 come in; the reserved bits never reach here.
module ecr_decode
    import ecr_pkg::*;
(
    input  logic [CTL_N-1:0] ctl_bits,
    input  logic             en_n,
    output ecr_ctl_t         ctl
);
    // Field mapping, forced to zero while the enable is inactive.
    always_comb begin
        ctl            = '0;
        if (!en_n) begin
            ctl.pwr_down   = ctl_bits[POS_PWR];
            ctl.cnt_load   = ctl_bits[POS_CNT];
            ctl.msel_route = ctl_bits[POS_MSEL];
            ctl.pre_route  = ctl_bits[POS_PRE];
            ctl.ref_oe     = ctl_bits[POS_OE];
        end
    end
endmodule

// File: rtl/enh_ctrl_reg.sv
// Module: enh_ctrl_reg (top)
// Enhancement control register: synchronizes the shared serial lines and
// strobes, stages serial bytes, loads the active byte on a validated
// strobe edge (serial) or the rising strobe (parallel), and drives gated
// control outputs. Assumes the mode inputs are static around load windows.
module enh_ctrl_reg
    import ecr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_direct,
    input  logic             mode_serial,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_wr,
    input  logic             enh_wr,
    input  logic [ECR_W-1:0] par_data,
    input  logic             enh_en_n,
    output logic             pwr_down,
    output logic             cnt_load,
    output logic             msel_route,
    output logic             pre_route,
    output logic             ref_oe,
    output logic             frame_err
);
    localparam int unsigned SW = ECR_W + 4;

    logic [SW-1:0]    sync_q;
    logic             sclk_s, sdata_s, swr_s, ewr_s;
    logic [ECR_W-1:0] par_s;
    logic             sclk_prev, ewr_prev;
    logic             sclk_rise, ewr_rise, ewr_fall;
    logic             ser_en, par_en;
    logic [ECR_W-1:0] stage;
    logic             cap, bad, par_load;
    logic [ECR_W-1:0] act_q;
    ecr_ctl_t         ctl;

    ecr_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({par_data, ser_clk, ser_data, ser_wr, enh_wr}),
        .q     (sync_q)
    );

    assign {par_s, sclk_s, sdata_s, swr_s, ewr_s} = sync_q;

    // Previous-cycle copies of the synchronized edge sources.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            ewr_prev  <= 1'b0;
        end else begin
            sclk_prev <= sclk_s;
            ewr_prev  <= ewr_s;
        end
    end

    assign sclk_rise = sclk_s && !sclk_prev;
    assign ewr_rise  = ewr_s && !ewr_prev;
    assign ewr_fall  = !ewr_s && ewr_prev;
    assign ser_en    = !mode_direct && mode_serial;
    assign par_en    = !mode_direct && !mode_serial;
    assign par_load  = par_en && ewr_rise;

    ecr_shift #(.W(ECR_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_en    (ser_en),
        .sclk_rise (sclk_rise),
        .sdata     (sdata_s),
        .ewr_s     (ewr_s),
        .ewr_rise  (ewr_rise),
        .ewr_fall  (ewr_fall),
        .swr_s     (swr_s),
        .stage     (stage),
        .cap       (cap),
        .bad       (bad)
    );

    // Active byte: serial capture or parallel load; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '0;
        else if (cap) act_q <= stage;
        else if (par_load) act_q <= par_s;
    end

    // Error pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_err <= 1'b0;
        else frame_err <= bad;
    end

    ecr_decode u_decode (
        .ctl_bits (act_q[CTL_N-1:0]),
        .en_n     (enh_en_n),
        .ctl      (ctl)
    );

    assign {pwr_down, cnt_load, msel_route, pre_route, ref_oe} = ctl;

    // R3
    // err_pulse_chk
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    // R3
    // err_hold_chk
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> $stable(act_q));

    // R2
    // act_on_event_chk
    act_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_q) |-> $past(cap || par_load));

    // R7
    // gate_off_chk
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enh_en_n |-> !(pwr_down || cnt_load || msel_route || pre_route || ref_oe));
endmodule

// File: tb/enh_ctrl_reg_tb.sv
module enh_ctrl_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_direct = 1'b0, mode_serial = 1'b1;
    logic       ser_clk = 1'b0, ser_data = 1'b0, ser_wr = 1'b0, enh_wr = 1'b0;
    logic [7:0] par_data = 8'h00;
    logic       enh_en_n = 1'b0;
    logic       pwr_down, cnt_load, msel_route, pre_route, ref_oe, frame_err;

    int tests = 0, fails = 0, err_seen = 0;
    logic [7:0] model = 8'h00;

    always #5 clk = ~clk;

    enh_ctrl_reg u_dut (
        .clk(clk), .rst_n(rst_n), .mode_direct(mode_direct), .mode_serial(mode_serial),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_wr(ser_wr), .enh_wr(enh_wr),
        .par_data(par_data), .enh_en_n(enh_en_n), .pwr_down(pwr_down),
        .cnt_load(cnt_load), .msel_route(msel_route), .pre_route(pre_route),
        .ref_oe(ref_oe), .frame_err(frame_err)
    );

    always @(negedge clk) if (rst_n && frame_err) err_seen++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [4:0] expect_out(input logic [7:0] b, input logic en_n);
        return en_n ? 5'b0 : {b[4], b[3], b[2], b[1], b[0]};
    endfunction

    task automatic chk(input string req);
        logic [4:0] act;
        logic [4:0] exp;
        act = {pwr_down, cnt_load, msel_route, pre_route, ref_oe};
        exp = expect_out(model, enh_en_n);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: outputs %b expected %b (byte %h)", req, act, exp, model);
        end
    endtask

    task automatic chk_err(input string req, input int exp);
        tests++;
        if (err_seen != exp) begin
            fails++;
            $display("FAIL %s: error pulses %0d expected %0d", req, err_seen, exp);
        end
    endtask

    // Serial window with nbits clocks; when blocked, ser_wr stays high throughout.
    task automatic ser_write(input logic [7:0] val, input int nbits, input logic blocked);
        ser_wr = blocked;
        enh_wr = 1'b1;
        tick(4);
        for (int i = 0; i < nbits; i++) begin
            ser_data = (i < 8) ? val[7-i] : 1'b0;
            tick(2);
            ser_clk = 1'b1;
            tick(4);
            ser_clk = 1'b0;
            tick(2);
        end
        chk("R2 mid-window");
        enh_wr = 1'b0;
        tick(6);
        ser_wr = 1'b0;
        if (nbits == 8 && !blocked && !mode_direct) model = val;
    endtask

    initial begin
        int e0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        chk("R10 reset state");
        chk_err("R3 no error at reset", 0);

        // Full serial sweep: R1 bit order and R8/R9 output mapping
        mode_direct = 1'b0; mode_serial = 1'b1;
        for (int v = 0; v < 256; v++) begin
            ser_write(8'(v), 8, 1'b0);
            chk("R1 R8 R9 serial load");
            if (v % 16 == 5) begin
                enh_en_n = 1'b1; tick(1); chk("R7 gated off");
                enh_en_n = 1'b0; tick(1); chk("R8 gated on");
            end
        end
        chk_err("R3 no error on good frames", 0);

        // Wrong bit counts
        ser_write(8'h1F, 8, 1'b0);
        e0 = err_seen;
        ser_write(8'hE0, 7, 1'b0);
        chk("R3 seven bits hold");
        chk_err("R3 seven bits pulse", e0 + 1);
        ser_write(8'hE0, 9, 1'b0);
        chk("R3 nine bits hold");
        chk_err("R3 nine bits pulse", e0 + 2);
        ser_write(8'hE0, 0, 1'b0);
        chk_err("R3 empty window pulse", e0 + 3);

        // ser_wr high blocks shifting and counting
        ser_write(8'h0A, 8, 1'b1);
        chk("R4 blocked window hold");
        chk_err("R4 blocked window counts zero", e0 + 4);
        ser_write(8'h15, 8, 1'b0);
        chk("R4 unblocked load");

        // Parallel sweep
        mode_serial = 1'b0;
        e0 = err_seen;
        for (int v = 0; v < 256; v++) begin
            par_data = 8'(v);
            tick(3);
            enh_wr = 1'b1;
            tick(2);
            if (v == 77) chk("R11 not before third edge");
            tick(4);
            model = 8'(v);
            chk("R5 parallel rising load");
            par_data = ~8'(v);
            tick(3);
            enh_wr = 1'b0;
            tick(6);
            chk("R5 falling edge ignored");
        end
        chk_err("R5 no error in parallel", e0);

        // Latency check: rising edge at negedge, due by third posedge
        par_data = 8'h1E;
        tick(3);
        enh_wr = 1'b1;
        tick(2);
        chk("R11 held before third edge");
        tick(1);
        model = 8'h1E;
        chk("R11 loaded at third edge");
        enh_wr = 1'b0;
        tick(6);

        // Direct mode ignores everything
        mode_direct = 1'b1;
        par_data = 8'h01;
        tick(3);
        enh_wr = 1'b1; tick(6); enh_wr = 1'b0; tick(6);
        chk("R6 direct parallel ignored");
        mode_serial = 1'b1;
        ser_write(8'h0B, 8, 1'b0);
        chk("R6 direct serial ignored");
        ser_write(8'h0B, 5, 1'b0);
        chk_err("R6 no error in direct", e0);

        // Reset clears
        mode_direct = 1'b0;
        ser_write(8'hFF, 8, 1'b0);
        chk("R10 preload");
        rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(1);
        model = 8'h00;
        chk("R10 reset clears");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: run incomplete, expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule